// File: doc/BRIEF.md
# Character Display Boot Sequencer

This block brings a character display controller out of power-up in 4-bit mode with no processor involved, then writes two text lines held in an internal string ROM. It drives a nibble-wide write port made of a nibble, a register-select bit and a write strobe, and the panel answers with a ready signal. Busy-flag reads go through a separate request line, and the panel returns each nibble with a valid strobe. Every delay is a parameter counted in clock cycles, so the block can be retimed for any clock.

A `start` pulse runs the full sequence. The block first sends four raw nibbles without busy checking. It then sends five setup commands, and after that, for each of two configured display rows, an address command followed by the characters of that row's string. Each byte goes out as two nibbles, high nibble first. The next byte waits until a busy-flag poll returns not-busy, and the number of polls is bounded. `done` rises when the sequence completes or when a poll budget runs out; in the second case `tmo_err` also rises. Once `done` is high, a power request sends a display-off or display-on command through the same checked path.

Top module: `lcd_boot_seq`

## Requirements
- R1: While reset is held, and in the cycle after reset, `lcd_wr`, `rd_req`, `done` and `tmo_err` are all low.
- R2: After `start`, the first four accepted writes are single nibbles 0x3, 0x3, 0x3, 0x2 with `lcd_rs`=0. No busy read is issued before them. Consecutive accepts are at least T_LONG cycles apart after the first nibble and at least T_SHORT cycles apart after each of the other three.
- R3: Every later byte is written as two accepted nibbles, bits 7:4 first and then bits 3:0, with at least T_NIB cycles between the two accepts.
- R4: The setup commands, all with `lcd_rs`=0, are 0x28, 0x0C, 0x06, 0x01 and 0x02, in that order.
- R5: A busy poll starts at least T_SHORT cycles after each checked byte. A poll is a high-nibble read followed by a low-nibble read, and bit 3 of the high nibble is the busy flag. The poll repeats while busy, and no write happens until a poll returns not-busy, so each byte costs exactly (busy answers + 1) polls.
- R6: If MAX_POLLS polls in a row are busy, the block stops writing and raises `done` and `tmo_err`. A nibble not returned within T_NIBWAIT cycles of the request counts as busy.
- R7: Each row starts with the command 0x80 OR offset, where the offset is 0x00 for row 0 and 0x28 for row 1. The string's bytes follow with `lcd_rs`=1 and stop before the first zero byte. ROM string 0 is "READY". ROM string 1 holds LEN_B characters, character i being 0x41 + (i mod 26).
- R8: No row receives more than MAX_COLS (default 40) characters, even when its string is longer.
- R9: A row parameter other than 0 or 1 makes the block skip that row entirely: no address command and no characters.
- R10: `done` rises after the last character of the second row and stays high until the next `start`. A `start` that arrives while the sequence runs has no effect. A `start` while idle clears `done` and `tmo_err`.
- R11: With `done` high, a `pwr_req` sends byte 0x08 when `pwr_on`=0 and byte 0x0C when `pwr_on`=1, as a busy-checked command.
- R12: `lcd_wr` stays high with `lcd_nib` and `lcd_rs` unchanged until the cycle in which `lcd_rdy` is seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that begins the boot sequence when idle |
| pwr_req | input | 1 | Pulse that requests a display power command once booted |
| pwr_on | input | 1 | Selects display on (1) or off (0) for a power request |
| lcd_nib | output | 4 | Nibble on the write port |
| lcd_rs | output | 1 | Register select: 1 for character data, 0 for commands |
| lcd_wr | output | 1 | Write strobe, held until ready |
| lcd_rdy | input | 1 | Panel accepts the current nibble |
| rd_req | output | 1 | Busy-flag nibble read request |
| rd_vld | input | 1 | Returned nibble is valid |
| rd_nib | input | 4 | Returned nibble |
| done | output | 1 | Sequence finished or aborted |
| tmo_err | output | 1 | Busy polling gave up |

## Verification
A corrupted phase or index register shows up as a wrong byte or register-select value on the write port, at the next accepted nibble pair after the fault. A broken delay or poll counter changes the spacing between accepts, or the number of read requests each byte costs. A lost busy decision shows up either as a write before a not-busy poll or as a missing or premature `tmo_err`, within one poll budget. The column counter and the row skip can only be seen in the total count of character writes, which is checked at `done`.

// File: rtl/lcd_seq_pkg.sv
// Package: shared phases, state encodings, command codes and helpers for the
// display boot sequencer. Assumes the panel uses the common 4-bit command set.
package lcd_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE, PH_INIT, PH_CMD, PH_LINE, PH_ADDR, PH_CHR, PH_PWR
    } phase_t;

    typedef enum logic [3:0] {
        X_IDLE, X_WHI, X_GAP, X_WLO, X_SETTLE, X_RHI, X_RGAP, X_RLO, X_POST
    } xfer_st_t;

    localparam logic [7:0] CMD_DISP_OFF = 8'h08;
    localparam logic [7:0] CMD_DISP_ON  = 8'h0C;
    localparam logic [7:0] CMD_ADDR     = 8'h80;
    localparam logic [7:0] ROW1_OFS     = 8'h28;
    localparam logic [7:0] RAW_WIDE     = 8'h30;
    localparam logic [7:0] RAW_NARROW   = 8'h20;
    localparam int         BUSY_BIT     = 3;
    localparam int         N_RAW        = 4;
    localparam int         N_SETUP      = 5;

    // Largest of three counts, used to size cycle counters.
    function automatic int unsigned max_of3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Setup command table, indexed in issue order.
    function automatic logic [7:0] setup_cmd(input logic [2:0] i);
        case (i)
            3'd0:    return 8'h28;
            3'd1:    return 8'h0C;
            3'd2:    return 8'h06;
            3'd3:    return 8'h01;
            default: return 8'h02;
        endcase
    endfunction

endpackage

// File: rtl/lcd_str_rom.sv
// String ROM: two zero-terminated strings, looked up combinationally.
// String 0 is a short fixed word; string 1 is generated arithmetically with
// LEN_B characters. Assumes pos never exceeds 2**PW-1.
module lcd_str_rom #(
    parameter int PW    = 6,
    parameter int LEN_B = 44
) (
    input  logic          line_sel,
    input  logic [PW-1:0] pos,
    output logic [7:0]    ch
);
    // Select the character for (line, position), zero past the end.
    always_comb begin
        ch = 8'h00;
        if (!line_sel) begin
            case (int'(pos))
                0:       ch = 8'h52;
                1:       ch = 8'h45;
                2:       ch = 8'h41;
                3:       ch = 8'h44;
                4:       ch = 8'h59;
                default: ch = 8'h00;
            endcase
        end else if (int'(pos) < LEN_B) begin
            ch = 8'h41 + 8'(int'(pos) % 26);
        end
    end
endmodule

// File: rtl/lcd_byte_xfer.sv
// Byte transfer engine: sends either one raw nibble followed by a fixed wait,
// or a full byte as two nibbles followed by busy-flag polling. Reports
// completion with a one-cycle fin pulse, plus tmo when the poll budget ran out.
// Assumes go only arrives while idle and every timing parameter is at least 1.
module lcd_byte_xfer
    import lcd_seq_pkg::*;
#(
    parameter int CW        = 20,
    parameter int T_NIB     = 500,
    parameter int T_SHORT   = 5000,
    parameter int T_RDGAP   = 50000,
    parameter int T_NIBWAIT = 50000,
    parameter int MAX_POLLS = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [7:0]    byte_i,
    input  logic          rs_i,
    input  logic          single_i,
    input  logic [CW-1:0] wait_i,
    input  logic          lcd_rdy,
    input  logic          rd_vld,
    input  logic [3:0]    rd_nib,
    output logic [3:0]    lcd_nib,
    output logic          lcd_rs,
    output logic          lcd_wr,
    output logic          rd_req,
    output logic          idle,
    output logic          fin,
    output logic          tmo
);
    localparam int PLW = $clog2(MAX_POLLS + 1);

    xfer_st_t       st_q;
    logic [7:0]     byte_q;
    logic           rs_q;
    logic           single_q;
    logic [CW-1:0]  cnt_q;
    logic [PLW-1:0] polls_q;
    logic [3:0]     hi_q;
    logic           fin_q;
    logic           tmo_q;

    // Transfer state machine: write nibbles, count gaps, poll the busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= X_IDLE;
            byte_q   <= '0;
            rs_q     <= 1'b0;
            single_q <= 1'b0;
            cnt_q    <= '0;
            polls_q  <= '0;
            hi_q     <= '0;
            fin_q    <= 1'b0;
            tmo_q    <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            tmo_q <= 1'b0;
            case (st_q)
                X_IDLE: if (go) begin
                    byte_q   <= byte_i;
                    rs_q     <= rs_i;
                    single_q <= single_i;
                    cnt_q    <= wait_i - CW'(1);
                    polls_q  <= '0;
                    st_q     <= X_WHI;
                end
                X_WHI: if (lcd_rdy) begin
                    if (single_q) begin
                        st_q <= X_POST;
                    end else begin
                        cnt_q <= CW'(T_NIB - 1);
                        st_q  <= X_GAP;
                    end
                end
                X_GAP: begin
                    if (cnt_q == '0) st_q <= X_WLO;
                    else             cnt_q <= cnt_q - CW'(1);
                end
                X_WLO: if (lcd_rdy) begin
                    cnt_q <= CW'(T_SHORT - 1);
                    st_q  <= X_SETTLE;
                end
                X_SETTLE: begin
                    if (cnt_q == '0) begin
                        cnt_q <= CW'(T_NIBWAIT - 1);
                        st_q  <= X_RHI;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                X_RHI: begin
                    if (rd_vld || cnt_q == '0) begin
                        hi_q  <= rd_vld ? rd_nib : 4'hF;
                        cnt_q <= CW'(T_RDGAP - 1);
                        st_q  <= X_RGAP;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                X_RGAP: begin
                    if (cnt_q == '0) begin
                        cnt_q <= CW'(T_NIBWAIT - 1);
                        st_q  <= X_RLO;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                X_RLO: begin
                    if (rd_vld || cnt_q == '0) begin
                        if (!hi_q[BUSY_BIT]) begin
                            fin_q <= 1'b1;
                            st_q  <= X_IDLE;
                        end else if (polls_q == PLW'(MAX_POLLS - 1)) begin
                            fin_q <= 1'b1;
                            tmo_q <= 1'b1;
                            st_q  <= X_IDLE;
                        end else begin
                            polls_q <= polls_q + PLW'(1);
                            cnt_q   <= CW'(T_NIBWAIT - 1);
                            st_q    <= X_RHI;
                        end
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                X_POST: begin
                    if (cnt_q == '0) begin
                        fin_q <= 1'b1;
                        st_q  <= X_IDLE;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                default: st_q <= X_IDLE;
            endcase
        end
    end

    // Port drive decoded from the transfer state.
    always_comb begin
        lcd_wr  = (st_q == X_WHI) || (st_q == X_WLO);
        lcd_nib = (st_q == X_WLO) ? byte_q[3:0] : byte_q[7:4];
        lcd_rs  = lcd_wr & rs_q;
        rd_req  = (st_q == X_RHI) || (st_q == X_RLO);
        idle    = (st_q == X_IDLE);
        fin     = fin_q;
        tmo     = tmo_q;
    end

    a_r12_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_wr && !lcd_rdy |=> lcd_wr && $stable(lcd_nib) && $stable(lcd_rs));
    a_r5_no_wr_during_rd: assert property (@(posedge clk) disable iff (!rst_n)
        !(lcd_wr && rd_req));
    a_r6_tmo_with_fin: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |-> fin);
    a_r6_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(polls_q) < MAX_POLLS);
endmodule

// File: rtl/lcd_boot_seq.sv
// Boot sequencer top: walks the raw power-up nibbles, the setup commands and
// two ROM rows, handing each item to the transfer engine and waiting for its
// completion. Accepts power commands after boot. Assumes the panel eventually
// raises lcd_rdy for every write.
module lcd_boot_seq
    import lcd_seq_pkg::*;
#(
    parameter int T_LONG    = 250000,
    parameter int T_SHORT   = 5000,
    parameter int T_NIB     = 500,
    parameter int T_RDGAP   = 50000,
    parameter int T_NIBWAIT = 50000,
    parameter int MAX_POLLS = 50,
    parameter int MAX_COLS  = 40,
    parameter int ROW_A     = 0,
    parameter int ROW_B     = 1,
    parameter int LEN_B     = 44
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       pwr_req,
    input  logic       pwr_on,
    output logic [3:0] lcd_nib,
    output logic       lcd_rs,
    output logic       lcd_wr,
    input  logic       lcd_rdy,
    output logic       rd_req,
    input  logic       rd_vld,
    input  logic [3:0] rd_nib,
    output logic       done,
    output logic       tmo_err
);
    localparam int CW = $clog2(max_of3(max_of3(T_LONG, T_SHORT, T_NIB), T_RDGAP, T_NIBWAIT) + 1) + 1;
    localparam int PW = $clog2(MAX_COLS + 1);
    localparam bit A_OK   = (ROW_A == 0) || (ROW_A == 1);
    localparam bit B_OK   = (ROW_B == 0) || (ROW_B == 1);
    localparam bit A_ROW1 = (ROW_A == 1);
    localparam bit B_ROW1 = (ROW_B == 1);

    phase_t        ph_q;
    logic [2:0]    idx_q;
    logic          line_q;
    logic [PW-1:0] pos_q;
    logic          pend_q;
    logic          done_q;
    logic          tmo_q;
    logic          pwr_on_q;

    logic [7:0]    ch;
    logic [7:0]    it_byte;
    logic          it_rs;
    logic          it_single;
    logic [CW-1:0] it_wait;
    logic          launch;
    logic          go;
    logic          eng_idle;
    logic          fin;
    logic          eng_tmo;
    logic          row_ok;
    logic          row_is1;
    logic          chr_end;

    lcd_str_rom #(.PW(PW), .LEN_B(LEN_B)) u_rom (
        .line_sel (line_q),
        .pos      (pos_q),
        .ch       (ch)
    );

    // Decode the current row and the end-of-string condition.
    always_comb begin
        row_ok  = line_q ? B_OK   : A_OK;
        row_is1 = line_q ? B_ROW1 : A_ROW1;
        chr_end = (pos_q == PW'(MAX_COLS)) || (ch == 8'h00);
    end

    // Build the item for the engine from the phase and its indices.
    always_comb begin
        it_byte   = 8'h00;
        it_rs     = 1'b0;
        it_single = 1'b0;
        it_wait   = CW'(T_SHORT);
        launch    = 1'b0;
        case (ph_q)
            PH_INIT: begin
                it_byte   = (idx_q == 3'(N_RAW - 1)) ? RAW_NARROW : RAW_WIDE;
                it_single = 1'b1;
                it_wait   = (idx_q == 3'd0) ? CW'(T_LONG) : CW'(T_SHORT);
                launch    = !pend_q;
            end
            PH_CMD: begin
                it_byte = setup_cmd(idx_q);
                launch  = !pend_q;
            end
            PH_ADDR: begin
                it_byte = CMD_ADDR | (row_is1 ? ROW1_OFS : 8'h00);
                launch  = !pend_q;
            end
            PH_CHR: begin
                it_byte = ch;
                it_rs   = 1'b1;
                launch  = !pend_q && !chr_end;
            end
            PH_PWR: begin
                it_byte = pwr_on_q ? CMD_DISP_ON : CMD_DISP_OFF;
                launch  = !pend_q;
            end
            default: launch = 1'b0;
        endcase
        go = launch && eng_idle;
    end

    lcd_byte_xfer #(
        .CW(CW), .T_NIB(T_NIB), .T_SHORT(T_SHORT), .T_RDGAP(T_RDGAP),
        .T_NIBWAIT(T_NIBWAIT), .MAX_POLLS(MAX_POLLS)
    ) u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .byte_i   (it_byte),
        .rs_i     (it_rs),
        .single_i (it_single),
        .wait_i   (it_wait),
        .lcd_rdy  (lcd_rdy),
        .rd_vld   (rd_vld),
        .rd_nib   (rd_nib),
        .lcd_nib  (lcd_nib),
        .lcd_rs   (lcd_rs),
        .lcd_wr   (lcd_wr),
        .rd_req   (rd_req),
        .idle     (eng_idle),
        .fin      (fin),
        .tmo      (eng_tmo)
    );

    // Sequencer: phase advance on start, row decisions and engine completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= PH_IDLE;
            idx_q    <= '0;
            line_q   <= 1'b0;
            pos_q    <= '0;
            pend_q   <= 1'b0;
            done_q   <= 1'b0;
            tmo_q    <= 1'b0;
            pwr_on_q <= 1'b0;
        end else begin
            if (go) pend_q <= 1'b1;
            case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        ph_q   <= PH_INIT;
                        idx_q  <= '0;
                        done_q <= 1'b0;
                        tmo_q  <= 1'b0;
                    end else if (pwr_req && done_q) begin
                        ph_q     <= PH_PWR;
                        pwr_on_q <= pwr_on;
                    end
                end
                PH_LINE: begin
                    pos_q <= '0;
                    if (row_ok)       ph_q <= PH_ADDR;
                    else if (line_q) begin ph_q <= PH_IDLE; done_q <= 1'b1; end
                    else             line_q <= 1'b1;
                end
                PH_CHR: if (!pend_q && chr_end) begin
                    if (line_q) begin ph_q <= PH_IDLE; done_q <= 1'b1; end
                    else        begin line_q <= 1'b1; ph_q <= PH_LINE; end
                end
                default: ;
            endcase
            if (pend_q && fin) begin
                pend_q <= 1'b0;
                if (eng_tmo) begin
                    ph_q   <= PH_IDLE;
                    done_q <= 1'b1;
                    tmo_q  <= 1'b1;
                end else begin
                    case (ph_q)
                        PH_INIT: begin
                            if (idx_q == 3'(N_RAW - 1)) begin ph_q <= PH_CMD; idx_q <= '0; end
                            else idx_q <= idx_q + 3'd1;
                        end
                        PH_CMD: begin
                            if (idx_q == 3'(N_SETUP - 1)) begin ph_q <= PH_LINE; line_q <= 1'b0; end
                            else idx_q <= idx_q + 3'd1;
                        end
                        PH_ADDR: ph_q <= PH_CHR;
                        PH_CHR:  pos_q <= pos_q + PW'(1);
                        PH_PWR:  ph_q <= PH_IDLE;
                        default: ;
                    endcase
                end
            end
        end
    end

    assign done    = done_q;
    assign tmo_err = tmo_q;

    a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);
    a_r8_col_cap: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pos_q) <= MAX_COLS);
    a_r7_data_only_in_text: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_wr && lcd_rs |-> ph_q == PH_CHR);
    a_r6_err_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |-> done);
    a_r2_no_read_in_raw: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ph_q != PH_INIT);
endmodule

// File: tb/lcd_boot_seq_bench.sv
`timescale 1ns/1ps
// Panel model: answers writes with ready, answers busy reads with nibbles
// (busy for the first busy_n polls after each write), logs accepted writes.
module lcd_panel_model (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [3:0] nib,
    input  logic       rs,
    input  logic       rd_req,
    output logic       rdy,
    output logic       vld,
    output logic [3:0] rnib
);
    logic [4:0] wlog [0:255];
    int wt [0:255];
    int nw = 0;
    int nhi = 0;
    int busy_n = 0;
    bit silent = 0;
    int first_rd_nw = -1;
    int first_rd_cyc = 0;
    int cyc = 0;
    int poll_i = 0;
    int dly = 0;
    bit lo_ph = 0;

    initial begin
        rdy = 0; vld = 0; rnib = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (!rst_n) begin
                rdy <= 0; vld <= 0; dly = 0; lo_ph = 0; poll_i = 0;
            end else begin
                if (wr && rdy) begin
                    wlog[nw] = {rs, nib}; wt[nw] = cyc; nw++;
                    poll_i = 0; lo_ph = 0;
                end
                rdy <= wr && !rdy;
                if (vld) vld <= 0;
                else if (rd_req && !silent) begin
                    if (dly >= 1) begin
                        vld <= 1; dly = 0;
                        if (!lo_ph) begin
                            rnib <= (poll_i < busy_n) ? 4'h8 : 4'h0;
                            nhi++;
                            if (first_rd_nw < 0) begin first_rd_nw = nw; first_rd_cyc = cyc; end
                        end else begin
                            rnib <= 4'h7;
                            poll_i++;
                        end
                        lo_ph = !lo_ph;
                    end else dly++;
                end
            end
        end
    end
endmodule

module lcd_boot_seq_bench;
    localparam int T_LONG = 40, T_SHORT = 8, T_NIB = 3, T_RDGAP = 4;
    localparam int T_NIBWAIT = 10, MAX_POLLS = 4, MAX_COLS = 40, LEN_B = 44;

    logic clk = 0;
    logic rst_n = 0;
    logic start_a = 0, start_b = 0, pwr_req = 0, pwr_on = 0;
    logic [3:0] nib_a, nib_b, rnib_a, rnib_b;
    logic rs_a, rs_b, wr_a, wr_b, rdy_a, rdy_b, rq_a, rq_b, vld_a, vld_b;
    logic done_a, done_b, tmo_a, tmo_b;

    int n_cmp = 0, n_bad = 0;
    logic [4:0] cap [0:127];
    int capt [0:127];

    always #2 clk = ~clk;

    lcd_boot_seq #(.T_LONG(T_LONG), .T_SHORT(T_SHORT), .T_NIB(T_NIB), .T_RDGAP(T_RDGAP),
        .T_NIBWAIT(T_NIBWAIT), .MAX_POLLS(MAX_POLLS), .MAX_COLS(MAX_COLS),
        .ROW_A(0), .ROW_B(1), .LEN_B(LEN_B)) u_lcd_boot_seq (
        .clk(clk), .rst_n(rst_n), .start(start_a), .pwr_req(pwr_req), .pwr_on(pwr_on),
        .lcd_nib(nib_a), .lcd_rs(rs_a), .lcd_wr(wr_a), .lcd_rdy(rdy_a),
        .rd_req(rq_a), .rd_vld(vld_a), .rd_nib(rnib_a), .done(done_a), .tmo_err(tmo_a));

    lcd_boot_seq #(.T_LONG(T_LONG), .T_SHORT(T_SHORT), .T_NIB(T_NIB), .T_RDGAP(T_RDGAP),
        .T_NIBWAIT(T_NIBWAIT), .MAX_POLLS(MAX_POLLS), .MAX_COLS(MAX_COLS),
        .ROW_A(1), .ROW_B(2), .LEN_B(LEN_B)) u_skip (
        .clk(clk), .rst_n(rst_n), .start(start_b), .pwr_req(1'b0), .pwr_on(1'b0),
        .lcd_nib(nib_b), .lcd_rs(rs_b), .lcd_wr(wr_b), .lcd_rdy(rdy_b),
        .rd_req(rq_b), .rd_vld(vld_b), .rd_nib(rnib_b), .done(done_b), .tmo_err(tmo_b));

    lcd_panel_model u_mdl_a (.clk(clk), .rst_n(rst_n), .wr(wr_a), .nib(nib_a), .rs(rs_a),
        .rd_req(rq_a), .rdy(rdy_a), .vld(vld_a), .rnib(rnib_a));
    lcd_panel_model u_mdl_b (.clk(clk), .rst_n(rst_n), .wr(wr_b), .nib(nib_b), .rs(rs_b),
        .rd_req(rq_b), .rdy(rdy_b), .vld(vld_b), .rnib(rnib_b));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] word_ch(input int i);
        case (i)
            0: return 8'h52; 1: return 8'h45; 2: return 8'h41; 3: return 8'h44;
            default: return 8'h59;
        endcase
    endfunction

    function automatic logic [7:0] setup_exp(input int i);
        case (i)
            0: return 8'h28; 1: return 8'h0C; 2: return 8'h06; 3: return 8'h01;
            default: return 8'h02;
        endcase
    endfunction

    // Expected byte k of the checked stream; vb selects the skipped-row build.
    function automatic logic [8:0] exp_item(input bit vb, input int k);
        if (k < 5) return {1'b0, setup_exp(k)};
        if (vb) begin
            if (k == 5) return {1'b0, 8'hA8};
            return {1'b1, word_ch(k - 6)};
        end
        if (k == 5)  return {1'b0, 8'h80};
        if (k < 11)  return {1'b1, word_ch(k - 6)};
        if (k == 11) return {1'b0, 8'hA8};
        return {1'b1, 8'h41 + 8'((k - 12) % 26)};
    endfunction

    task automatic check_cap(input bit vb, input int nbytes);
        logic [8:0] got, exp;
        chk(cap[0] == 5'h03, "R2 raw nibble 0", cap[0], 5'h03);
        chk(cap[1] == 5'h03, "R2 raw nibble 1", cap[1], 5'h03);
        chk(cap[2] == 5'h03, "R2 raw nibble 2", cap[2], 5'h03);
        chk(cap[3] == 5'h02, "R2 raw nibble 3", cap[3], 5'h02);
        chk(capt[1] - capt[0] >= T_LONG,  "R2 long wait", capt[1] - capt[0], T_LONG);
        chk(capt[2] - capt[1] >= T_SHORT, "R2 short wait", capt[2] - capt[1], T_SHORT);
        chk(capt[4] - capt[3] >= T_SHORT, "R2 short wait last", capt[4] - capt[3], T_SHORT);
        chk(capt[5] - capt[4] >= T_NIB,   "R3 nibble gap", capt[5] - capt[4], T_NIB);
        for (int k = 0; k < nbytes; k++) begin
            got = {cap[4+2*k][4] & cap[5+2*k][4], cap[4+2*k][3:0], cap[5+2*k][3:0]};
            exp = exp_item(vb, k);
            if (k < 5)                  chk(got == exp, "R4 setup byte", got, exp);
            else if (!vb && k >= 12)    chk(got == exp, "R8 row1 text", got, exp);
            else                        chk(got == exp, "R7 row byte", got, exp);
            chk(cap[4+2*k][4] == cap[5+2*k][4], "R3 rs both nibbles", cap[5+2*k][4], cap[4+2*k][4]);
        end
    endtask

    task automatic grab_a(input int base, input int n);
        for (int i = 0; i < n; i++) begin cap[i] = u_mdl_a.wlog[base+i]; capt[i] = u_mdl_a.wt[base+i]; end
    endtask

    task automatic wait_done_a(input int lim);
        int k = 0;
        while (!done_a && k < lim) begin @(negedge clk); k++; end
        chk(done_a == 1'b1, "R10 done reached", done_a, 1);
    endtask

    task automatic pulse_start_a();
        @(negedge clk) start_a = 1;
        @(negedge clk) start_a = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int base, bh, t0;
        repeat (4) @(negedge clk);
        chk({wr_a, rq_a, done_a, tmo_a} == 4'b0, "R1 reset outputs", {wr_a, rq_a, done_a, tmo_a}, 0);
        rst_n = 1;
        @(negedge clk);
        chk({wr_a, rq_a, done_a, tmo_a} == 4'b0, "R1 after reset", {wr_a, rq_a, done_a, tmo_a}, 0);

        // Full boot on both instances; a stray start mid-run on A.
        @(negedge clk) begin start_a = 1; start_b = 1; end
        @(negedge clk) begin start_a = 0; start_b = 0; end
        repeat (600) @(negedge clk);
        chk(done_a == 1'b0, "R10 busy before stray start", done_a, 0);
        pulse_start_a();
        wait_done_a(20000);
        chk(tmo_a == 1'b0, "R6 no error on clean boot", tmo_a, 0);
        chk(u_mdl_a.nw == 4 + 2*52, "R8 write count capped", u_mdl_a.nw, 4 + 2*52);
        grab_a(0, 4 + 2*52);
        check_cap(1'b0, 52);
        chk(u_mdl_a.first_rd_nw == 6, "R2 first read after first byte", u_mdl_a.first_rd_nw, 6);
        chk(u_mdl_a.first_rd_cyc - u_mdl_a.wt[5] >= T_SHORT, "R5 settle before poll",
            u_mdl_a.first_rd_cyc - u_mdl_a.wt[5], T_SHORT);
        chk(u_mdl_a.nhi == 52, "R5 one poll per idle byte", u_mdl_a.nhi, 52);

        // Skipped row on the second instance.
        begin
            int k = 0;
            while (!done_b && k < 20000) begin @(negedge clk); k++; end
        end
        chk(done_b == 1'b1, "R9 done with skipped row", done_b, 1);
        chk(u_mdl_b.nw == 4 + 2*11, "R9 no writes for bad row", u_mdl_b.nw, 4 + 2*11);
        for (int i = 0; i < 26; i++) begin cap[i] = u_mdl_b.wlog[i]; capt[i] = u_mdl_b.wt[i]; end
        check_cap(1'b1, 11);

        // Reboot with two busy answers per byte.
        u_mdl_a.busy_n = 2;
        base = u_mdl_a.nw; bh = u_mdl_a.nhi;
        pulse_start_a();
        chk(done_a == 1'b0, "R10 start clears done", done_a, 0);
        wait_done_a(40000);
        chk(u_mdl_a.nhi - bh == 3*52, "R5 polls per busy byte", u_mdl_a.nhi - bh, 3*52);
        chk(u_mdl_a.nw - base == 4 + 2*52, "R5 stream length under busy", u_mdl_a.nw - base, 4 + 2*52);
        grab_a(base, 4 + 2*52);
        check_cap(1'b0, 52);

        // Power commands after boot.
        for (int p = 0; p < 2; p++) begin
            base = u_mdl_a.nw; bh = u_mdl_a.nhi;
            @(negedge clk) begin pwr_on = (p == 1); pwr_req = 1; end
            @(negedge clk) pwr_req = 0;
            repeat (200) @(negedge clk);
            chk(u_mdl_a.nw - base == 2, "R11 power write count", u_mdl_a.nw - base, 2);
            chk({u_mdl_a.wlog[base], u_mdl_a.wlog[base+1]} == (p == 1 ? 10'h00C : 10'h008),
                "R11 power byte", {u_mdl_a.wlog[base], u_mdl_a.wlog[base+1]}, (p == 1 ? 10'h00C : 10'h008));
            chk(u_mdl_a.nhi - bh == 3, "R11 power busy checked", u_mdl_a.nhi - bh, 3);
            chk(done_a == 1'b1 && tmo_a == 1'b0, "R11 flags kept", {done_a, tmo_a}, 2'b10);
        end

        // Always busy: abort after the poll budget.
        u_mdl_a.busy_n = 1000;
        base = u_mdl_a.nw; bh = u_mdl_a.nhi;
        pulse_start_a();
        wait_done_a(20000);
        chk(tmo_a == 1'b1, "R6 error raised", tmo_a, 1);
        chk(u_mdl_a.nw - base == 6, "R6 writes stop", u_mdl_a.nw - base, 6);
        chk(u_mdl_a.nhi - bh == MAX_POLLS, "R6 poll budget", u_mdl_a.nhi - bh, MAX_POLLS);
        repeat (100) @(negedge clk);
        chk(u_mdl_a.nw - base == 6 && !wr_a, "R6 idle after abort", u_mdl_a.nw - base, 6);

        // No replies at all: every nibble times out and counts as busy.
        u_mdl_a.busy_n = 0; u_mdl_a.silent = 1;
        base = u_mdl_a.nw; bh = u_mdl_a.nhi;
        pulse_start_a();
        chk(tmo_a == 1'b0, "R10 start clears error", tmo_a, 0);
        t0 = u_mdl_a.cyc;
        wait_done_a(20000);
        chk(tmo_a == 1'b1, "R6 silent panel error", tmo_a, 1);
        chk(u_mdl_a.nw - base == 6, "R6 silent writes stop", u_mdl_a.nw - base, 6);
        chk(u_mdl_a.cyc - t0 >= MAX_POLLS*(2*T_NIBWAIT + T_RDGAP), "R6 silent duration",
            u_mdl_a.cyc - t0, MAX_POLLS*(2*T_NIBWAIT + T_RDGAP));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule